// File: doc/BRIEF.md
# Processor Trace Status Encoder

This block turns per-instruction events from an embedded CPU core into a compact real-time trace stream on two 4-bit ports. The status port marks every completed instruction with one status code. After that code, an optional payload can follow: either the memory operand the instruction touched, or the target address of a taken change of flow. A size marker on the status port announces the payload, and the payload itself then appears on the data port one nibble per clock, least significant nibble first.

A small control register decides what is shown. Operand capture is filtered by reference direction: reads, writes, both or neither. Branch-target reporting has its own enable bit, and it sends only the low-order bytes of the new target that differ from the previously reported target. Events are queued in a short FIFO so that the core can keep completing instructions while a long payload is shifted out. When the FIFO is full, the block holds the core through a ready signal, so no trace record is ever lost.

Top module: `trace_status_encoder`

## Requirements
- R1: Each event accepted (`ev_valid` and `ev_ready` both high at a clock edge) produces exactly one cycle with status code 0x1 on `trc_status`. These codes appear in the order in which the events were accepted, and back-to-back events without payload produce back-to-back 0x1 cycles.
- R2: When no status, marker or payload nibble is being emitted, `trc_status` is 0x0 and `trc_data` is 0x0. Reset leaves both at 0x0 with `ev_ready` high.
- R3: An operand is reported with a size marker. `ev_size` 0 (byte) gives marker 0x8 and 2 nibbles. `ev_size` 1 (halfword) gives marker 0x9 and 4 nibbles. `ev_size` 2 or 3 (word) gives marker 0xB and 8 nibbles. The nibbles are taken from the low end of `ev_data`.
- R4: An operand is shown only if its direction is enabled. Control bit 0 enables reads (`ev_rd`) and control bit 1 enables writes (`ev_wr`); with both bits set, both directions are shown.
- R5: An operand is shown only when `ev_mem` is high, meaning the effective address referenced memory. A register-only instruction never carries an operand payload.
- R6: With control bit 2 set, an event with `ev_cof` high reports `ev_target` as its payload. This payload takes priority over any operand of the same event. With bit 2 clear, `ev_cof` has no effect.
- R7: A reported target uses marker 0xB (4 bytes) if bits 31:24 differ from the previous reported target. Otherwise it uses 0xA (3 bytes) if bits 23:16 differ. In all other cases it uses 0x9 (2 bytes). The previous target is 0 after reset, and it is updated only when a target is reported.
- R8: The marker appears in the cycle directly after its 0x1 status code. The payload nibbles follow on `trc_data` in the next cycles, least significant first, while `trc_status` is 0x0. `trc_data` is 0x0 during status and marker cycles.
- R9: `ev_ready` is low exactly while the event queue is full. Every accepted event still appears in the stream.
- R10: A control write (`cfg_we`) applies only to events accepted after the write's clock edge. An event accepted at the same edge as the write uses the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 3 | Control value: bit0 reads, bit1 writes, bit2 branch targets |
| ev_valid | input | 1 | An instruction completes this cycle |
| ev_ready | output | 1 | Event can be accepted (queue not full) |
| ev_mem | input | 1 | Effective address referenced memory |
| ev_rd | input | 1 | Memory operand is a read |
| ev_wr | input | 1 | Memory operand is a write |
| ev_size | input | 2 | Operand size: 0 byte, 1 halfword, 2/3 word |
| ev_data | input | 32 | Operand value |
| ev_cof | input | 1 | Taken change of flow qualifying for target report |
| ev_target | input | 32 | Change-of-flow target address |
| trc_status | output | 4 | Status / size marker stream |
| trc_data | output | 4 | Payload nibble stream |

## Verification
On every cycle, the assertions check the shape of the stream. A marker only follows a 0x1 code and is itself followed by a nibble cycle. The data port stays quiet under status and marker codes. The queue never overflows or underflows, and register-only events never build a payload. What a payload contains can only be shown by the bench scenarios, because it needs a model of the filtering, the byte-count choice against the previous target and the timing of control writes: which operand is shown, which marker is chosen and which nibbles follow. The same holds for whether every record survives a backlog.

// File: rtl/trace_pkg.sv
package trace_pkg;
    localparam int TRC_W = 32;

    localparam logic [3:0] PST_IDLE = 4'h0;
    localparam logic [3:0] PST_DONE = 4'h1;
    localparam logic [3:0] MK_1B    = 4'h8;
    localparam logic [3:0] MK_2B    = 4'h9;
    localparam logic [3:0] MK_3B    = 4'hA;
    localparam logic [3:0] MK_4B    = 4'hB;

    localparam int CFG_RD  = 0;
    localparam int CFG_WR  = 1;
    localparam int CFG_TGT = 2;

    typedef struct packed {
        logic             has;
        logic [3:0]       mark;
        logic [3:0]       nibs;
        logic [TRC_W-1:0] data;
    } trace_rec_t;
endpackage

// File: rtl/trace_event_encoder.sv
module trace_event_encoder
    import trace_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_wdata,
    input  logic             ev_fire,
    input  logic             ev_mem,
    input  logic             ev_rd,
    input  logic             ev_wr,
    input  logic [1:0]       ev_size,
    input  logic [TRC_W-1:0] ev_data,
    input  logic             ev_cof,
    input  logic [TRC_W-1:0] ev_target,
    output trace_rec_t       rec
);
    typedef struct packed {
        logic [2:0]       cfg;
        logic [TRC_W-1:0] last_tgt;
    } enc_state_t;

    enc_state_t st_d, st_q;
    logic [TRC_W-1:0] diff;
    logic tgt_en, op_en;

    always_comb begin
        st_d   = st_q;
        rec    = '0;
        diff   = ev_target ^ st_q.last_tgt;
        tgt_en = st_q.cfg[CFG_TGT] && ev_cof;
        op_en  = ev_mem && ((ev_rd && st_q.cfg[CFG_RD]) || (ev_wr && st_q.cfg[CFG_WR]));
        if (tgt_en) begin
            rec.has  = 1'b1;
            rec.data = ev_target;
            if (diff[31:24] != '0) begin
                rec.mark = MK_4B;
                rec.nibs = 4'd8;
            end else if (diff[23:16] != '0) begin
                rec.mark = MK_3B;
                rec.nibs = 4'd6;
            end else begin
                rec.mark = MK_2B;
                rec.nibs = 4'd4;
            end
            if (ev_fire) st_d.last_tgt = ev_target;
        end else if (op_en) begin
            rec.has  = 1'b1;
            rec.data = ev_data;
            case (ev_size)
                2'd0:    begin rec.mark = MK_1B; rec.nibs = 4'd2; end
                2'd1:    begin rec.mark = MK_2B; rec.nibs = 4'd4; end
                default: begin rec.mark = MK_4B; rec.nibs = 4'd8; end
            endcase
        end
        if (cfg_we) st_d.cfg = cfg_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_regonly_hidden_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_fire && !ev_mem && !ev_cof) |-> !rec.has);
    assert_tgt_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_fire && !st_q.cfg[CFG_TGT] && !ev_mem) |-> !rec.has);
endmodule

// File: rtl/trace_fifo.sv
module trace_fifo
    import trace_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  trace_rec_t wr_rec,
    input  logic       pop,
    output trace_rec_t rd_rec,
    output logic       empty,
    output logic       full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        trace_rec_t [DEPTH-1:0] mem;
        logic [PW-1:0]          wptr;
        logic [PW-1:0]          rptr;
        logic [CW-1:0]          cnt;
    } fifo_state_t;

    fifo_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        empty  = (st_q.cnt == '0);
        full   = (st_q.cnt == CW'(DEPTH));
        rd_rec = st_q.mem[st_q.rptr];
        if (push) begin
            st_d.mem[st_q.wptr] = wr_rec;
            st_d.wptr = (st_q.wptr == PW'(DEPTH - 1)) ? '0 : st_q.wptr + 1'b1;
        end
        if (pop) begin
            st_d.rptr = (st_q.rptr == PW'(DEPTH - 1)) ? '0 : st_q.rptr + 1'b1;
        end
        if (push && !pop)      st_d.cnt = st_q.cnt + 1'b1;
        else if (pop && !push) st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    assert_no_underflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    assert_full_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |=> full);
endmodule

// File: rtl/trace_serializer.sv
module trace_serializer
    import trace_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  trace_rec_t head,
    input  logic       empty,
    output logic       pop,
    output logic [3:0] pst,
    output logic [3:0] dd
);
    typedef struct packed {
        logic [3:0]       mark_pend;
        logic [TRC_W-1:0] shift;
        logic [3:0]       left;
        logic [3:0]       pst;
        logic [3:0]       dd;
    } ser_state_t;

    ser_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        pop      = 1'b0;
        st_d.pst = PST_IDLE;
        st_d.dd  = 4'h0;
        if (st_q.mark_pend != 4'h0) begin
            st_d.pst       = st_q.mark_pend;
            st_d.mark_pend = 4'h0;
        end else if (st_q.left != 4'd0) begin
            st_d.dd    = st_q.shift[3:0];
            st_d.shift = st_q.shift >> 4;
            st_d.left  = st_q.left - 4'd1;
        end else if (!empty) begin
            pop            = 1'b1;
            st_d.pst       = PST_DONE;
            st_d.mark_pend = head.has ? head.mark : 4'h0;
            st_d.shift     = head.data;
            st_d.left      = head.has ? head.nibs : 4'd0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pst = st_q.pst;
    assign dd  = st_q.dd;

    assert_marker_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pst[3] == 1'b1) |-> ($past(pst) == PST_DONE));
    assert_marker_then_nibble_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pst[3] == 1'b1) |=> (pst == PST_IDLE));
    assert_quiet_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pst != PST_IDLE) |-> (dd == 4'h0));
endmodule

// File: rtl/trace_status_encoder.sv
module trace_status_encoder
    import trace_pkg::*;
#(
    parameter int QDEPTH = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [2:0]  cfg_wdata,
    input  logic        ev_valid,
    output logic        ev_ready,
    input  logic        ev_mem,
    input  logic        ev_rd,
    input  logic        ev_wr,
    input  logic [1:0]  ev_size,
    input  logic [31:0] ev_data,
    input  logic        ev_cof,
    input  logic [31:0] ev_target,
    output logic [3:0]  trc_status,
    output logic [3:0]  trc_data
);
    trace_rec_t new_rec, head_rec;
    logic fire, q_full, q_empty, q_pop;

    assign ev_ready = !q_full;
    assign fire     = ev_valid && ev_ready;

    trace_event_encoder i_enc (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .ev_fire(fire), .ev_mem(ev_mem), .ev_rd(ev_rd), .ev_wr(ev_wr),
        .ev_size(ev_size), .ev_data(ev_data), .ev_cof(ev_cof),
        .ev_target(ev_target), .rec(new_rec)
    );

    trace_fifo #(.DEPTH(QDEPTH)) i_q (
        .clk(clk), .rst_n(rst_n), .push(fire), .wr_rec(new_rec),
        .pop(q_pop), .rd_rec(head_rec), .empty(q_empty), .full(q_full)
    );

    trace_serializer i_ser (
        .clk(clk), .rst_n(rst_n), .head(head_rec), .empty(q_empty),
        .pop(q_pop), .pst(trc_status), .dd(trc_data)
    );

    assert_stall_when_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_ready && !q_pop) |=> !ev_ready);
endmodule

// File: tb/test_trace_status_encoder.sv
module test_trace_status_encoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_wdata = '0;
    logic        ev_valid = 1'b0;
    logic        ev_ready;
    logic        ev_mem = 1'b0, ev_rd = 1'b0, ev_wr = 1'b0, ev_cof = 1'b0;
    logic [1:0]  ev_size = '0;
    logic [31:0] ev_data = '0, ev_target = '0;
    logic [3:0]  trc_status, trc_data;

    always #5 clk = ~clk;

    trace_status_encoder i_trace_status_encoder (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_mem(ev_mem), .ev_rd(ev_rd),
        .ev_wr(ev_wr), .ev_size(ev_size), .ev_data(ev_data), .ev_cof(ev_cof),
        .ev_target(ev_target), .trc_status(trc_status), .trc_data(trc_data)
    );

    typedef struct {
        logic [3:0]  mk;
        logic [31:0] val;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0, fails = 0;
    int idle_err = 0;
    logic [2:0]  m_cfg = '0;
    logic [31:0] m_last = '0;
    bit saw_stall = 0;
    bit done = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [35:0] act, input logic [35:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // monitor: decodes the stream and scores it against the expected queue
    int mst = 0, need = 0, got = 0;
    logic [3:0]  mmk;
    logic [31:0] mval;

    task automatic close_rec(input logic [3:0] mk, input logic [31:0] v);
        exp_t e;
        if (exp_q.size() == 0) begin
            check(0, "R1", "unexpected record", {mk, v}, '0);
        end else begin
            e = exp_q.pop_front();
            check(mk == e.mk && v == e.val, e.tag, "record", {mk, v}, {e.mk, e.val});
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (!ev_ready) saw_stall = 1;
            if (mst == 2) begin
                if (trc_status != 4'h0) check(0, "R8", "status during payload", {32'h0, trc_status}, '0);
                mval = mval | (32'(trc_data) << (4 * got));
                got++;
                if (got == need) begin
                    close_rec(mmk, mval);
                    mst = 0;
                end
            end else if (mst == 1 && trc_status[3]) begin
                if (trc_data != 4'h0) check(0, "R8", "data under marker", {32'h0, trc_data}, '0);
                mmk = trc_status;
                need = (trc_status == 4'h8) ? 2 : (trc_status == 4'h9) ? 4 :
                       (trc_status == 4'hA) ? 6 : 8;
                got = 0;
                mval = '0;
                mst = 2;
            end else begin
                if (mst == 1) begin
                    close_rec(4'h0, 32'h0);
                    mst = 0;
                end
                if (trc_status == 4'h1) begin
                    if (trc_data != 4'h0) check(0, "R8", "data under status", {32'h0, trc_data}, '0);
                    mst = 1;
                end else if (trc_status == 4'h0) begin
                    if (trc_data != 4'h0) idle_err++;
                end else begin
                    check(0, "R8", "marker without status", {32'h0, trc_status}, 36'h1);
                end
            end
        end
    end

    task automatic push_exp(input logic [3:0] mk, input logic [31:0] v, input string tag);
        exp_t e;
        e.mk = mk; e.val = v; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // model of one accepted event using the control value in effect
    task automatic model(input logic [2:0] c, input logic mem, input logic rd,
                         input logic wr, input logic [1:0] sz, input logic [31:0] d,
                         input logic cof, input logic [31:0] t, input string tag);
        logic [31:0] df;
        df = t ^ m_last;
        if (c[2] && cof) begin
            if (df[31:24] != 0)      push_exp(4'hB, t, tag);
            else if (df[23:16] != 0) push_exp(4'hA, t & 32'h00FF_FFFF, tag);
            else                     push_exp(4'h9, t & 32'h0000_FFFF, tag);
            m_last = t;
        end else if (mem && ((rd && c[0]) || (wr && c[1]))) begin
            if (sz == 2'd0)      push_exp(4'h8, d & 32'hFF, tag);
            else if (sz == 2'd1) push_exp(4'h9, d & 32'hFFFF, tag);
            else                 push_exp(4'hB, d, tag);
        end else begin
            push_exp(4'h0, 32'h0, tag);
        end
    endtask

    task automatic send(input logic mem, input logic rd, input logic wr,
                        input logic [1:0] sz, input logic [31:0] d,
                        input logic cof, input logic [31:0] t, input string tag);
        @(negedge clk);
        ev_valid = 1; ev_mem = mem; ev_rd = rd; ev_wr = wr; ev_size = sz;
        ev_data = d; ev_cof = cof; ev_target = t;
        while (!ev_ready) @(negedge clk);
        @(posedge clk);
        model(m_cfg, mem, rd, wr, sz, d, cof, t, tag);
    endtask

    task automatic set_cfg(input logic [2:0] c);
        @(negedge clk);
        ev_valid = 0; cfg_we = 1; cfg_wdata = c;
        @(posedge clk);
        m_cfg = c;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic drain();
        int n = 0;
        @(negedge clk);
        ev_valid = 0;
        while ((exp_q.size() != 0 || mst != 0) && n < 2000) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        check(exp_q.size() == 0, "R1", "records outstanding", 36'(exp_q.size()), '0);
        check(idle_err == 0, "R2", "nonzero data while idle", 36'(idle_err), '0);
        check(saw_stall, "R9", "ready deasserted under backlog", {35'h0, saw_stall}, 36'h1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            check(0, "R1", "watchdog expired", '0, 36'h1);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(trc_status == 0 && trc_data == 0 && ev_ready, "R2", "reset state",
              {27'h0, ev_ready, trc_status, trc_data}, 36'h100);
        rst_n = 1;

        // R1 plain instructions back to back, R4 nothing enabled
        send(0, 0, 0, 0, 0, 0, 0, "R1");
        send(0, 0, 0, 0, 0, 0, 0, "R1");
        send(0, 0, 0, 0, 0, 0, 0, "R1");
        send(1, 1, 0, 2, 32'hDEAD_BEEF, 0, 0, "R4");
        drain();

        // R3 sizes with reads enabled, R4 write filtered
        set_cfg(3'b001);
        send(1, 1, 0, 0, 32'h1234_56A5, 0, 0, "R3");
        send(1, 1, 0, 1, 32'h1234_C3D2, 0, 0, "R3");
        send(1, 1, 0, 2, 32'h8765_4321, 0, 0, "R3");
        send(1, 1, 0, 3, 32'h0F1E_2D3C, 0, 0, "R3");
        send(1, 0, 1, 2, 32'h5555_AAAA, 0, 0, "R4");
        drain();

        // R4 writes only
        set_cfg(3'b010);
        send(1, 0, 1, 1, 32'h0000_BEEF, 0, 0, "R4");
        send(1, 1, 0, 1, 32'h0000_CAFE, 0, 0, "R4");
        // R5 register-only with both enabled
        set_cfg(3'b011);
        send(0, 1, 0, 2, 32'h1111_2222, 0, 0, "R5");
        send(0, 0, 1, 0, 32'h0000_0077, 0, 0, "R5");
        send(1, 1, 0, 0, 32'h0000_0042, 0, 0, "R4");
        drain();

        // R6/R7 branch targets
        set_cfg(3'b100);
        send(0, 0, 0, 0, 0, 1, 32'h0000_1234, "R7");
        send(0, 0, 0, 0, 0, 1, 32'h0056_1234, "R7");
        send(0, 0, 0, 0, 0, 1, 32'h7856_1234, "R7");
        send(0, 0, 0, 0, 0, 1, 32'h7856_1299, "R7");
        send(0, 0, 0, 0, 0, 1, 32'h7856_1299, "R7");
        set_cfg(3'b111);
        send(1, 1, 0, 2, 32'hAAAA_BBBB, 1, 32'h7956_0000, "R6");
        set_cfg(3'b001);
        send(1, 1, 0, 0, 32'h0000_00E1, 1, 32'hFFFF_FFFF, "R6");
        drain();

        // R10 control write in the same cycle as an event
        set_cfg(3'b000);
        @(negedge clk);
        cfg_we = 1; cfg_wdata = 3'b001;
        ev_valid = 1; ev_mem = 1; ev_rd = 1; ev_wr = 0; ev_size = 1;
        ev_data = 32'h0000_9876; ev_cof = 0;
        @(posedge clk);
        model(3'b000, 1, 1, 0, 1, 32'h0000_9876, 0, 0, "R10");
        m_cfg = 3'b001;
        @(negedge clk);
        cfg_we = 0; ev_valid = 0;
        send(1, 1, 0, 1, 32'h0000_5432, 0, 0, "R10");
        drain();

        // R9 backlog of word reads
        for (int i = 0; i < 12; i++)
            send(1, 1, 0, 2, 32'h0102_0304 * (i + 1), 0, 0, "R9");
        send(0, 0, 0, 0, 0, 0, 0, "R9");
        drain();

        done = 1;
        finish_run();
    end
endmodule